// File: doc/BRIEF.md
# Banked Data Memory Address Mapper

This block turns a data-memory access of a small 8-bit register-file machine into one physical target. The access arrives as a 7-bit direct offset plus a bank-select bit, so each of the two banks spans 128 locations. When the direct offset is zero, the access goes through an 8-bit pointer value instead, and all 8 pointer bits give the full address, bank included. Each resolved address is classed as a special-function register, a general-purpose RAM byte, or a hole that reads as zero.

The block holds the general-purpose RAM itself: 96 bytes behind bank 0 and 32 more behind bank 1. The top 16 bytes of bank 1 alias the top 16 bytes of bank 0 as shared RAM. Special-function registers live elsewhere. For those the block only reports a select index, and it folds the offsets that are mirrored across banks onto one index. All results are registered and appear one clock after the access is presented.

Top module: `bank_dmap`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid`, `ram_hit`, `sfr_hit`, `zero_rd`, `common_hit`, `ram_idx`, `sfr_idx` and `rd_data` are all zero.
- R2: An access presented with `acc_valid` high at a rising edge produces `out_valid` high after that edge. A cycle with `acc_valid` low produces `out_valid` low and all hit flags low.
- R3: Bank 0 offsets 20h–7Fh (full address 20h–7Fh) hit RAM with `ram_idx` = offset − 20h. A byte written there reads back unchanged.
- R4: Bank 1 offsets 20h–3Fh (full address A0h–BFh) hit RAM with `ram_idx` = offset + 40h, which is 60h–7Fh.
- R5: Full addresses 70h–7Fh and F0h–FFh both hit RAM index 50h–5Fh, with `common_hit` high. A write through either bank is visible through the other.
- R6: Full addresses C0h–EFh give `zero_rd` high and `rd_data` zero. A write there changes no RAM byte.
- R7: Offsets 01h–1Fh select an SFR. `sfr_hit` is high and the 6-bit `sfr_idx` = {bank, offset[4:0]}.
- R8: The mirrored SFR offsets 02h, 03h, 04h, 0Ah and 0Bh give `sfr_idx` = {0, offset[4:0]} in both banks.
- R9: A direct offset of 00h takes the effective address from `ptr_val` (bit 7 = bank), and `bank_sel` is ignored.
- R10: A pointer access whose pointer holds 00h or 80h gives `zero_rd` high with no RAM or SFR hit, and a write there changes no RAM byte.
- R11: With `out_valid` high, exactly one of `ram_hit`, `sfr_hit` and `zero_rd` is high.
- R12: `rd_data` is zero except for a RAM read. A write access reports zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| dir_addr | input | 7 | Direct offset within the bank; 00h selects pointer access |
| bank_sel | input | 1 | Bank for direct access |
| ptr_val | input | 8 | Pointer value used when `dir_addr` is 00h |
| wr_data | input | 8 | Write data |
| out_valid | output | 1 | Result valid |
| ram_hit | output | 1 | Access resolved to general-purpose RAM |
| sfr_hit | output | 1 | Access resolved to an SFR |
| zero_rd | output | 1 | Access resolved to a hole (reads zero, writes dropped) |
| common_hit | output | 1 | RAM hit lies in the shared region |
| ram_idx | output | 7 | Physical RAM index |
| sfr_idx | output | 6 | SFR select index |
| rd_data | output | 8 | Read data, zero unless RAM read |

## Verification
The bench writes the hole range C0h–EFh and the self-pointing pointer values 00h/80h, then re-reads every RAM byte. A decoder that leaked those writes would corrupt a RAM byte, and the re-read would show it. The alias pair is written through one bank and read through the other. A design that mapped F0h–FFh to its own storage would return stale data there, and it would also drop `common_hit`. Every SFR offset is swept in both banks, which catches a mirrored offset left with the bank bit set. Pointer accesses are run with `bank_sel` set to the opposite of the pointer's bank, so an address built from the direct bank bit gives the wrong index.

// File: rtl/bank_dmap_pkg.sv
package bank_dmap_pkg;
  typedef enum logic [1:0] {
    REG_HOLE = 2'd0,
    REG_SFR  = 2'd1,
    REG_GPR  = 2'd2
  } region_e;
endpackage

// File: rtl/bank_dmap_resolve.sv
// Chooses between the direct bank/offset pair and the pointer value.
module bank_dmap_resolve #(
  parameter int DIR_W = 7
) (
  input  logic [DIR_W-1:0] dir_addr,
  input  logic             bank_sel,
  input  logic [DIR_W:0]   ptr_val,
  output logic [DIR_W:0]   eff_addr
);
  logic via_ptr;

  always_comb begin
    via_ptr  = (dir_addr == '0);
    eff_addr = via_ptr ? ptr_val : {bank_sel, dir_addr};
  end
endmodule

// File: rtl/bank_dmap_decode.sv
// Classifies a full effective address into SFR, RAM or hole.
module bank_dmap_decode
  import bank_dmap_pkg::*;
#(
  parameter int DIR_W      = 7,
  parameter int SFR_CNT    = 32,
  parameter int GPR1_CNT   = 32,
  parameter int COMMON_CNT = 16,
  parameter int IDX_W      = 7,
  parameter int SFR_OW     = 5,
  parameter logic [SFR_CNT-1:0] SHARED_MASK = 'h0C1C
) (
  input  logic [DIR_W:0]   eff_addr,
  output region_e          region,
  output logic [IDX_W-1:0] ram_idx,
  output logic [SFR_OW:0]  sfr_idx,
  output logic             common
);
  localparam int BANK_SPAN = 1 << DIR_W;
  localparam int GPR0_CNT  = BANK_SPAN - SFR_CNT;
  localparam logic [DIR_W-1:0] SFR_END   = DIR_W'(SFR_CNT);
  localparam logic [DIR_W-1:0] B1_END    = DIR_W'(SFR_CNT + GPR1_CNT);
  localparam logic [DIR_W-1:0] COM_START = DIR_W'(BANK_SPAN - COMMON_CNT);
  localparam logic [IDX_W-1:0] B1_BASE   = IDX_W'(GPR0_CNT);

  logic [DIR_W-1:0] off;
  logic [DIR_W-1:0] span;
  logic             hi;

  always_comb begin
    off     = eff_addr[DIR_W-1:0];
    hi      = eff_addr[DIR_W];
    span    = off - SFR_END;
    region  = REG_HOLE;
    ram_idx = '0;
    sfr_idx = '0;
    common  = 1'b0;
    if (off == '0) begin
      // pointer aimed at the pointer pseudo-location: hole
      region = REG_HOLE;
    end else if (off < SFR_END) begin
      region  = REG_SFR;
      sfr_idx = {hi & ~SHARED_MASK[off[SFR_OW-1:0]], off[SFR_OW-1:0]};
    end else if (!hi) begin
      region  = REG_GPR;
      ram_idx = IDX_W'(span);
      common  = (off >= COM_START);
    end else if (off < B1_END) begin
      region  = REG_GPR;
      ram_idx = B1_BASE + IDX_W'(span);
    end else if (off >= COM_START) begin
      region  = REG_GPR;
      ram_idx = IDX_W'(span);
      common  = 1'b1;
    end
  end
endmodule

// File: rtl/bank_dmap_ram.sv
// Single-port read-first RAM, written for block RAM inference.
module bank_dmap_ram #(
  parameter int DEPTH = 128,
  parameter int AW    = 7,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wd;
      q <= mem[addr];
    end
  end
endmodule

// File: rtl/bank_dmap.sv
module bank_dmap
  import bank_dmap_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int DIR_W      = 7,
  parameter int SFR_CNT    = 32,
  parameter int GPR1_CNT   = 32,
  parameter int COMMON_CNT = 16,
  parameter logic [SFR_CNT-1:0] SHARED_MASK = 'h0C1C,
  localparam int BANK_SPAN = 1 << DIR_W,
  localparam int RAM_DEPTH = BANK_SPAN - SFR_CNT + GPR1_CNT,
  localparam int IDX_W     = $clog2(RAM_DEPTH),
  localparam int SFR_OW    = $clog2(SFR_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [DIR_W-1:0]  dir_addr,
  input  logic              bank_sel,
  input  logic [DIR_W:0]    ptr_val,
  input  logic [DATA_W-1:0] wr_data,
  output logic              out_valid,
  output logic              ram_hit,
  output logic              sfr_hit,
  output logic              zero_rd,
  output logic              common_hit,
  output logic [IDX_W-1:0]  ram_idx,
  output logic [SFR_OW:0]   sfr_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DIR_W:0]    eff_addr;
  region_e           region;
  logic [IDX_W-1:0]  dec_idx;
  logic [SFR_OW:0]   dec_sfr;
  logic              dec_common;
  logic              is_gpr;
  logic [DATA_W-1:0] ram_q;
  logic              rd_gate;

  bank_dmap_resolve #(.DIR_W(DIR_W)) u_resolve (
    .dir_addr (dir_addr),
    .bank_sel (bank_sel),
    .ptr_val  (ptr_val),
    .eff_addr (eff_addr)
  );

  bank_dmap_decode #(
    .DIR_W      (DIR_W),
    .SFR_CNT    (SFR_CNT),
    .GPR1_CNT   (GPR1_CNT),
    .COMMON_CNT (COMMON_CNT),
    .IDX_W      (IDX_W),
    .SFR_OW     (SFR_OW),
    .SHARED_MASK(SHARED_MASK)
  ) u_decode (
    .eff_addr (eff_addr),
    .region   (region),
    .ram_idx  (dec_idx),
    .sfr_idx  (dec_sfr),
    .common   (dec_common)
  );

  assign is_gpr = acc_valid && (region == REG_GPR);

  bank_dmap_ram #(.DEPTH(RAM_DEPTH), .AW(IDX_W), .DW(DATA_W)) u_ram (
    .clk  (clk),
    .en   (is_gpr),
    .we   (is_gpr && acc_write),
    .addr (dec_idx),
    .wd   (wr_data),
    .q    (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      ram_hit    <= 1'b0;
      sfr_hit    <= 1'b0;
      zero_rd    <= 1'b0;
      common_hit <= 1'b0;
      ram_idx    <= '0;
      sfr_idx    <= '0;
      rd_gate    <= 1'b0;
    end else begin
      out_valid  <= acc_valid;
      ram_hit    <= is_gpr;
      sfr_hit    <= acc_valid && (region == REG_SFR);
      zero_rd    <= acc_valid && (region == REG_HOLE);
      common_hit <= is_gpr && dec_common;
      ram_idx    <= is_gpr ? dec_idx : '0;
      sfr_idx    <= (acc_valid && (region == REG_SFR)) ? dec_sfr : '0;
      rd_gate    <= is_gpr && !acc_write;
    end
  end

  assign rd_data = rd_gate ? ram_q : '0;
endmodule

// File: rtl/bank_dmap_chk.sv
module bank_dmap_chk #(
  parameter int DATA_W     = 8,
  parameter int DIR_W      = 7,
  parameter int SFR_CNT    = 32,
  parameter int GPR1_CNT   = 32,
  parameter int COMMON_CNT = 16,
  parameter int IDX_W      = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [DIR_W-1:0]  dir_addr,
  input logic              bank_sel,
  input logic [DIR_W:0]    ptr_val,
  input logic              out_valid,
  input logic              ram_hit,
  input logic              sfr_hit,
  input logic              zero_rd,
  input logic              common_hit,
  input logic [IDX_W-1:0]  ram_idx,
  input logic [DATA_W-1:0] rd_data
);
  localparam int BANK_SPAN = 1 << DIR_W;
  localparam logic [DIR_W-1:0] HOLE_LO = DIR_W'(SFR_CNT + GPR1_CNT);
  localparam logic [DIR_W-1:0] HOLE_HI = DIR_W'(BANK_SPAN - COMMON_CNT);
  localparam logic [IDX_W-1:0] COM_IDX = IDX_W'(BANK_SPAN - SFR_CNT - COMMON_CNT);

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> out_valid);

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !out_valid && !ram_hit && !sfr_hit && !zero_rd);

  assert_one_target_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones({ram_hit, sfr_hit, zero_rd}) == 1);

  assert_zero_data_R12: assert property (@(posedge clk) disable iff (rst)
    (!ram_hit || $past(acc_write)) |-> rd_data == '0);

  assert_hole_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && bank_sel && dir_addr >= HOLE_LO && dir_addr < HOLE_HI)
    |=> zero_rd && !ram_hit);

  assert_self_ptr_R10: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && dir_addr == '0 && ptr_val[DIR_W-1:0] == '0)
    |=> zero_rd && !ram_hit && !sfr_hit);

  assert_alias_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && bank_sel && dir_addr >= HOLE_HI) |=> common_hit);

  assert_common_range_R5: assert property (@(posedge clk) disable iff (rst)
    common_hit |-> ram_hit && ram_idx >= COM_IDX);
endmodule

bind bank_dmap bank_dmap_chk #(
  .DATA_W     (DATA_W),
  .DIR_W      (DIR_W),
  .SFR_CNT    (SFR_CNT),
  .GPR1_CNT   (GPR1_CNT),
  .COMMON_CNT (COMMON_CNT),
  .IDX_W      (IDX_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .dir_addr   (dir_addr),
  .bank_sel   (bank_sel),
  .ptr_val    (ptr_val),
  .out_valid  (out_valid),
  .ram_hit    (ram_hit),
  .sfr_hit    (sfr_hit),
  .zero_rd    (zero_rd),
  .common_hit (common_hit),
  .ram_idx    (ram_idx),
  .rd_data    (rd_data)
);

// File: tb/bank_dmap_test.sv
module bank_dmap_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_valid = 1'b0;
  logic       acc_write = 1'b0;
  logic [6:0] dir_addr = '0;
  logic       bank_sel = 1'b0;
  logic [7:0] ptr_val = '0;
  logic [7:0] wr_data = '0;
  logic       out_valid, ram_hit, sfr_hit, zero_rd, common_hit;
  logic [6:0] ram_idx;
  logic [5:0] sfr_idx;
  logic [7:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [7:0] shadow [128];

  always #10 clk = ~clk;

  bank_dmap uut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .dir_addr(dir_addr), .bank_sel(bank_sel), .ptr_val(ptr_val),
    .wr_data(wr_data), .out_valid(out_valid), .ram_hit(ram_hit),
    .sfr_hit(sfr_hit), .zero_rd(zero_rd), .common_hit(common_hit),
    .ram_idx(ram_idx), .sfr_idx(sfr_idx), .rd_data(rd_data)
  );

  function automatic bit mirrored(input logic [6:0] off);
    return off == 7'h02 || off == 7'h03 || off == 7'h04 || off == 7'h0A || off == 7'h0B;
  endfunction

  // kind: 0 hole, 1 sfr, 2 ram
  task automatic expect_map(input logic [7:0] ea, output int kind,
                            output logic [6:0] idx, output logic [5:0] sidx,
                            output logic com, output string tag);
    logic [6:0] off = ea[6:0];
    logic       b   = ea[7];
    kind = 0; idx = '0; sidx = '0; com = 1'b0; tag = "R6";
    if (off == 7'h00) begin
      tag = "R10";
    end else if (off < 7'h20) begin
      kind = 1;
      sidx = {b & ~mirrored(off), off[4:0]};
      tag  = mirrored(off) ? "R8" : "R7";
    end else if (!b) begin
      kind = 2; idx = off - 7'h20; com = off >= 7'h70;
      tag  = com ? "R5" : "R3";
    end else if (off < 7'h40) begin
      kind = 2; idx = off + 7'h40; tag = "R4";
    end else if (off >= 7'h70) begin
      kind = 2; idx = off - 7'h20; com = 1'b1; tag = "R5";
    end
  endtask

  task automatic access(input logic [6:0] d, input logic b, input logic [7:0] p,
                        input logic w, input logic [7:0] wd);
    logic [7:0] ea;
    int kind;
    logic [6:0] eidx;
    logic [5:0] esidx;
    logic ecom;
    string tag;
    logic [7:0] erd;
    ea = (d == 7'h00) ? p : {b, d};
    expect_map(ea, kind, eidx, esidx, ecom, tag);
    if (d == 7'h00 && ea[6:0] != 7'h00) tag = {tag, "/R9"};
    erd = (kind == 2 && !w) ? shadow[eidx] : 8'h00;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; dir_addr = d; bank_sel = b;
    ptr_val = p; wr_data = wd;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    checks++;
    if (out_valid !== 1'b1 || ram_hit !== (kind == 2) || sfr_hit !== (kind == 1) ||
        zero_rd !== (kind == 0) || common_hit !== ecom || ram_idx !== eidx ||
        sfr_idx !== esidx || rd_data !== erd) begin
      fails++;
      $display("FAIL %s/R11/R12 ea=%h: got v%b r%b s%b z%b c%b idx=%h sidx=%h rd=%h exp r%b s%b z%b c%b idx=%h sidx=%h rd=%h",
               tag, ea, out_valid, ram_hit, sfr_hit, zero_rd, common_hit, ram_idx,
               sfr_idx, rd_data, kind == 2, kind == 1, kind == 0, ecom, eidx, esidx, erd);
    end
    if (w && kind == 2) shadow[eidx] = wd;
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if ({out_valid, ram_hit, sfr_hit, zero_rd, common_hit} !== 5'b0 ||
        ram_idx !== '0 || sfr_idx !== '0 || rd_data !== '0) begin
      fails++;
      $display("FAIL %s: got v%b r%b s%b z%b c%b idx=%h sidx=%h rd=%h exp all zero",
               tag, out_valid, ram_hit, sfr_hit, zero_rd, common_hit, ram_idx, sfr_idx, rd_data);
    end
  endtask

  task automatic read_all_ram;
    for (int a = 32; a < 128; a++) access(7'(a), 1'b0, 8'h00, 1'b0, 8'h00);
    for (int a = 32; a < 64; a++) access(7'(a), 1'b1, 8'h00, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_idle("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 after reset");

    // R3/R4: fill every RAM byte, then read back
    for (int a = 32; a < 128; a++) access(7'(a), 1'b0, 8'h00, 1'b1, 8'($urandom));
    for (int a = 32; a < 64; a++)  access(7'(a), 1'b1, 8'h00, 1'b1, 8'($urandom));
    read_all_ram();

    // R5: alias both directions
    access(7'h75, 1'b1, 8'h00, 1'b1, 8'h3C);
    access(7'h75, 1'b0, 8'h00, 1'b0, 8'h00);
    access(7'h7A, 1'b0, 8'h00, 1'b1, 8'hC3);
    access(7'h7A, 1'b1, 8'h00, 1'b0, 8'h00);

    // R6: writes into the hole leave RAM untouched
    for (int a = 64; a < 112; a++) access(7'(a), 1'b1, 8'h00, 1'b1, 8'hA5);
    // R10: self-pointing pointer writes are dropped
    access(7'h00, 1'b0, 8'h80, 1'b1, 8'h5A);
    access(7'h00, 1'b1, 8'h00, 1'b1, 8'h5A);
    read_all_ram();

    // R9: pointer bank overrides bank_sel
    access(7'h00, 1'b0, 8'hA3, 1'b1, 8'h77);
    access(7'h23, 1'b1, 8'h00, 1'b0, 8'h00);
    access(7'h00, 1'b1, 8'h41, 1'b0, 8'h00);
    access(7'h00, 1'b1, 8'h03, 1'b0, 8'h00);

    // R7/R8: every SFR offset in both banks
    for (int a = 1; a < 32; a++) begin
      access(7'(a), 1'b0, 8'h00, 1'b0, 8'h00);
      access(7'(a), 1'b1, 8'h00, 1'b1, 8'h11);
    end

    // R2: idle cycle after an access
    access(7'h30, 1'b0, 8'h00, 1'b0, 8'h00);
    @(negedge clk);
    check_idle("R2 idle");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      access(r[6:0], r[7], r[15:8], r[16], r[31:24]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule